// File: doc/BRIEF.md
# Audio Link Input Frame Serializer

This block sits on the codec side of a serial audio link. It produces the frames that travel from the codec back to the controller on the data-in line. The line runs on the 12.288 MHz bit clock, and one frame takes about 20.8 µs, which gives a 48 kHz frame rate. When the controller's frame sync input goes from low to high, the block latches a parallel snapshot of its inputs: a ready flag, one valid flag per data slot, and one 20-bit payload per data slot. It then shifts out a 16-bit tag slot and twelve 20-bit data slots, one bit per rising clock edge and most significant bit first. A full frame is 256 bits.

The tag starts with the ready flag and then carries the per-slot valid flags. Its spare low bits are zero. A slot whose valid flag is clear is sent as twenty zeros, whatever its payload input holds. Once the last bit of slot 12 has gone out, the line rests at zero until the next sync rising edge.

The control is one state machine with three states:
- `FS_IDLE`: the line is driven low.
- `FS_TAG`: the tag bits below the ready bit are being shifted out.
- `FS_SLOT`: a data slot is being shifted out.

It has these transitions:
- *frame start*: any state goes to `FS_TAG` on a sync rising edge.
- *tag done*: `FS_TAG` goes to `FS_SLOT` after tag bit 0.
- *slot advance*: `FS_SLOT` stays in `FS_SLOT` with the next slot after bit 0 of slots 1 to 11.
- *frame done*: `FS_SLOT` goes to `FS_IDLE` after bit 0 of slot 12.

Top module: `infrm_serializer`

## Requirements
- R1: While reset is asserted, and after reset as long as no sync rising edge has been sampled, `sdata_o` is 0.
- R2: A sync rising edge is a clock edge that samples `sync_i` high when the previous edge sampled it low. That same edge drives frame bit 0, the ready flag, taken from `ready_i`, onto `sdata_o`.
- R3: Frame bit n appears on `sdata_o` after the n-th rising edge following the start edge, for n from 0 to 255. The 256 bits are the 16-bit tag, then slots 1 to 12 in that order at 20 bits each. Every slot is sent most significant bit first.
- R4: Tag bits 14 down to 3 (frame bits 1 to 12) carry `slot_valid_i[0]` to `slot_valid_i[11]`, which are the valid flags for slots 1 to 12.
- R5: Tag bits 2 to 0 (frame bits 13 to 15) are always 0.
- R6: Slot n takes its payload from `slot_data_i[(n-1)*20 +: 20]`. If `slot_valid_i[n-1]` was 0 at the start edge, all 20 bits of slot n are sent as 0.
- R7: The ready flag, valid flags and payloads are captured at the start edge. Changing them later in the frame has no effect on the frame in progress.
- R8: After frame bit 255, `sdata_o` stays 0 until the next sync rising edge.
- R9: Holding `sync_i` high does not start another frame. Only a low-to-high transition does.
- R10: A sync rising edge in the middle of a frame abandons that frame. The new frame starts at that edge with freshly captured inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; all launches happen on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Frame sync from the controller |
| ready_i | input | 1 | Codec ready flag, sent as tag bit 15 |
| slot_valid_i | input | 12 | Valid flags; bit k is slot k+1 |
| slot_data_i | input | 240 | Slot payloads; slot k+1 at bits [k*20 +: 20] |
| sdata_o | output | 1 | Serial data-in line to the controller |

## Verification
The bench builds the block with its default parameters: twelve slots of 20 bits and a 16-bit tag. With these values it checks the exact 256-bit frame length, each slot's wrap from bit 0 to bit 19 of the next slot, and the move from slot 12 into idle, all against frames it computes itself. The same values expose three tag spare bits, so zero padding inside the tag can be checked. They also make the slot 12 to idle transition meet a following sync edge with nothing in between.

// File: rtl/infrm_pkg.sv
package infrm_pkg;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_TAG  = 2'd1,
        FS_SLOT = 2'd2
    } frm_state_e;

endpackage

// File: rtl/infrm_sync_detect.sv
module infrm_sync_detect (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sync_i,
    output logic start_o
);

    logic sync_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= 1'b0;
        end else begin
            sync_q <= sync_i;
        end
    end

    assign start_o = sync_i & ~sync_q;

    // Sync held high cannot start two frames on back-to-back edges.
    assert_no_double_start_R9: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        start_o |=> !start_o
    );

endmodule

// File: rtl/infrm_snapshot.sv
module infrm_snapshot #(
    parameter int SLOTS  = 12,
    parameter int SLOT_W = 20,
    parameter int TAG_W  = 16
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      start_i,
    input  logic [SLOTS-1:0]          valid_i,
    input  logic [SLOTS*SLOT_W-1:0]   data_i,
    output logic [TAG_W-2:0]          tag_o,
    output logic [SLOTS*SLOT_W-1:0]   data_o
);

    localparam int PAY_W  = SLOTS * SLOT_W;
    localparam int TAIL_W = TAG_W - 1;
    localparam int PAD    = TAIL_W - SLOTS;

    logic [TAIL_W-1:0] tag_d, tag_q;
    logic [PAY_W-1:0]  data_d, data_q;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign tag_d[TAIL_W-1-s] = valid_i[s];
        assign data_d[s*SLOT_W +: SLOT_W] =
            valid_i[s] ? data_i[s*SLOT_W +: SLOT_W] : '0;
    end

    if (PAD > 0) begin : g_pad
        assign tag_d[PAD-1:0] = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tag_q  <= '0;
            data_q <= '0;
        end else if (start_i) begin
            tag_q  <= tag_d;
            data_q <= data_d;
        end
    end

    assign tag_o  = tag_q;
    assign data_o = data_q;

    // The captured frame contents are frozen between start edges.
    assert_snapshot_hold_R7: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> ($stable(data_q) && $stable(tag_q))
    );

endmodule

// File: rtl/infrm_sequencer.sv
module infrm_sequencer
    import infrm_pkg::*;
#(
    parameter int SLOTS  = 12,
    parameter int SLOT_W = 20,
    parameter int TAG_W  = 16
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      start_i,
    input  logic                      ready_i,
    input  logic [TAG_W-2:0]          tag_i,
    input  logic [SLOTS*SLOT_W-1:0]   data_i,
    output logic                      sdata_o
);

    localparam int PAY_W  = SLOTS * SLOT_W;
    localparam int TAIL_W = TAG_W - 1;
    localparam int PAD    = TAIL_W - SLOTS;
    localparam int IDX_W  = $clog2(TAG_W > SLOT_W ? TAG_W : SLOT_W);
    localparam int SL_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int POS_W  = $clog2(PAY_W);

    frm_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [SL_W-1:0]   slot_q, slot_d;
    logic              bit_d;
    logic              sdata_q;
    logic [POS_W-1:0]  pos;
    logic [IDX_W-1:0]  vpos;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= FS_IDLE;
            idx_q   <= '0;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            slot_q  <= slot_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        slot_d  = slot_q;
        if (start_i) begin
            state_d = FS_TAG;
            idx_d   = IDX_W'(TAG_W - 2);
            slot_d  = '0;
        end else begin
            unique case (state_q)
                FS_IDLE: begin
                end
                FS_TAG: begin
                    if (idx_q == '0) begin
                        state_d = FS_SLOT;
                        idx_d   = IDX_W'(SLOT_W - 1);
                        slot_d  = '0;
                    end else begin
                        idx_d = idx_q - 1'b1;
                    end
                end
                FS_SLOT: begin
                    if (idx_q == '0) begin
                        if (slot_q == SL_W'(SLOTS - 1)) begin
                            state_d = FS_IDLE;
                        end else begin
                            slot_d = slot_q + 1'b1;
                            idx_d  = IDX_W'(SLOT_W - 1);
                        end
                    end else begin
                        idx_d = idx_q - 1'b1;
                    end
                end
                default: state_d = FS_IDLE;
            endcase
        end
    end

    // Bit selection for the next launch
    assign pos  = POS_W'(slot_q) * POS_W'(SLOT_W) + POS_W'(idx_q);
    assign vpos = IDX_W'(TAIL_W - 1) - IDX_W'(slot_q);

    always_comb begin
        bit_d = 1'b0;
        if (start_i) begin
            bit_d = ready_i;
        end else begin
            unique case (state_q)
                FS_IDLE: bit_d = 1'b0;
                FS_TAG:  bit_d = tag_i[idx_q];
                FS_SLOT: bit_d = data_i[pos];
                default: bit_d = 1'b0;
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sdata_q <= 1'b0;
        end else begin
            sdata_q <= bit_d;
        end
    end

    assign sdata_o = sdata_q;

    assert_first_bit_ready_R2: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (sdata_o == $past(ready_i))
    );

    assert_start_enters_tag_R2: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (state_q == FS_TAG)
    );

    assert_counters_in_range_R3: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        (state_q == FS_SLOT) |-> ((int'(idx_q) < SLOT_W) && (int'(slot_q) < SLOTS))
    );

    assert_stuffed_slot_zero_R6: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        (!start_i && state_q == FS_SLOT && !tag_i[vpos]) |=> !sdata_o
    );

    assert_idle_line_low_R8: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        (!start_i && state_q == FS_IDLE) |=> !sdata_o
    );

    if (PAD > 0) begin : g_pad_chk
        assert_tag_pad_zero_R5: assert property (
            @(posedge clk_i) disable iff (!rst_ni)
            (!start_i && state_q == FS_TAG && int'(idx_q) < PAD) |=> !sdata_o
        );
    end

endmodule

// File: rtl/infrm_serializer.sv
module infrm_serializer #(
    parameter int SLOTS  = 12,
    parameter int SLOT_W = 20,
    parameter int TAG_W  = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     sync_i,
    input  logic                     ready_i,
    input  logic [SLOTS-1:0]         slot_valid_i,
    input  logic [SLOTS*SLOT_W-1:0]  slot_data_i,
    output logic                     sdata_o
);

    localparam int PAY_W  = SLOTS * SLOT_W;
    localparam int TAIL_W = TAG_W - 1;

    logic              start;
    logic [TAIL_W-1:0] tag_tail;
    logic [PAY_W-1:0]  pay_snap;

    infrm_sync_detect u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sync_i  (sync_i),
        .start_o (start)
    );

    infrm_snapshot #(
        .SLOTS  (SLOTS),
        .SLOT_W (SLOT_W),
        .TAG_W  (TAG_W)
    ) u_snap (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start),
        .valid_i (slot_valid_i),
        .data_i  (slot_data_i),
        .tag_o   (tag_tail),
        .data_o  (pay_snap)
    );

    infrm_sequencer #(
        .SLOTS  (SLOTS),
        .SLOT_W (SLOT_W),
        .TAG_W  (TAG_W)
    ) u_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start),
        .ready_i (ready_i),
        .tag_i   (tag_tail),
        .data_i  (pay_snap),
        .sdata_o (sdata_o)
    );

endmodule

// File: tb/infrm_serializer_tb.sv
module infrm_serializer_tb_top;

    localparam int SLOTS  = 12;
    localparam int SLOT_W = 20;
    localparam int PAY_W  = SLOTS * SLOT_W;
    localparam int FRM    = 256;
    localparam int NVEC   = 8;

    // {ready, valid[11:0], seed[15:0]}
    localparam logic [28:0] VEC_TAB [NVEC] = '{
        {1'b1, 12'hFFF, 16'h1234},
        {1'b0, 12'h000, 16'hBEEF},
        {1'b1, 12'hAAA, 16'h0F0F},
        {1'b1, 12'h555, 16'hFFFF},
        {1'b0, 12'hFFF, 16'h8001},
        {1'b1, 12'h801, 16'h4A5C},
        {1'b1, 12'h3C0, 16'h0000},
        {1'b0, 12'h00F, 16'h7E81}
    };

    logic             clk;
    logic             rst_n;
    logic             sync;
    logic             ready;
    logic [SLOTS-1:0] valid;
    logic [PAY_W-1:0] data;
    logic             sdata;

    int checks;
    int fails;

    infrm_serializer dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .sync_i       (sync),
        .ready_i      (ready),
        .slot_valid_i (valid),
        .slot_data_i  (data),
        .sdata_o      (sdata)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    function automatic logic [PAY_W-1:0] make_payload(input logic [15:0] seed);
        logic [PAY_W-1:0] p;
        p = '0;
        for (int s = 0; s < SLOTS; s++) begin
            p[s*SLOT_W +: SLOT_W] = 20'({seed, 4'h0} ^ (s * 20'h09E37)) + 20'(seed) + 20'(s) + 20'h80001;
        end
        return p;
    endfunction

    function automatic logic [FRM-1:0] build_frame(input logic r,
                                                   input logic [SLOTS-1:0] v,
                                                   input logic [PAY_W-1:0] d);
        logic [FRM-1:0] f;
        f = '0;
        f[FRM-1] = r;
        for (int s = 0; s < SLOTS; s++) begin
            f[FRM-2-s] = v[s];
            if (v[s]) f[PAY_W-1-s*SLOT_W -: SLOT_W] = d[s*SLOT_W +: SLOT_W];
        end
        return f;
    endfunction

    task automatic check_vec(input string tag, input logic [FRM-1:0] got,
                             input logic [FRM-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, got, exp);
        end
    endtask

    // Raise sync, then collect the 256 bits of the frame it starts.
    task automatic run_frame(input logic keep, output logic [FRM-1:0] got);
        @(negedge clk);
        sync = 1'b1;
        @(posedge clk);
        for (int n = 0; n < FRM; n++) begin
            @(negedge clk);
            got[FRM-1-n] = sdata;
            if (n == 0 && !keep) sync = 1'b0;
        end
    endtask

    task automatic idle_check(input string tag, input int cycles);
        logic bad;
        bad = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sdata !== 1'b0) bad = 1'b1;
        end
        check_bit(tag, bad, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [FRM-1:0] got, exp, exp_a, exp_b, got_a;
        checks = 0;
        fails  = 0;
        rst_n  = 1'b0;
        sync   = 1'b0;
        ready  = 1'b0;
        valid  = '0;
        data   = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_bit("R1 reset line", sdata, 1'b0);
        rst_n = 1'b1;
        ready = 1'b1;
        valid = '1;
        data  = make_payload(16'hC3C3);
        idle_check("R1 no sync after reset", 12);

        // R2 R3 R4 R6: table of frames
        for (int v = 0; v < NVEC; v++) begin
            ready = VEC_TAB[v][28];
            valid = VEC_TAB[v][27:16];
            data  = make_payload(VEC_TAB[v][15:0]);
            exp   = build_frame(ready, valid, data);
            run_frame(1'b0, got);
            check_vec($sformatf("R2 R3 R4 R6 vector %0d", v), got, exp);
        end

        // R5: spare tag bits with every slot valid
        ready = 1'b1;
        valid = '1;
        data  = make_payload(16'h5A5A);
        run_frame(1'b0, got);
        check_vec("R5 tag pad bits", {253'd0, got[242:240]}, '0);

        // R8: line rests low after a frame
        idle_check("R8 idle after frame", 30);

        // R9: sync held high through and beyond the frame
        ready = 1'b0;
        valid = 12'h96C;
        data  = make_payload(16'h2468);
        exp   = build_frame(ready, valid, data);
        run_frame(1'b1, got);
        check_vec("R9 frame with sync held", got, exp);
        idle_check("R9 no restart while high", 40);
        @(negedge clk);
        sync = 1'b0;

        // R7: inputs change mid-frame
        ready = 1'b1;
        valid = 12'h0FF;
        data  = make_payload(16'h1357);
        exp   = build_frame(ready, valid, data);
        @(negedge clk);
        sync = 1'b1;
        @(posedge clk);
        for (int n = 0; n < FRM; n++) begin
            @(negedge clk);
            got[FRM-1-n] = sdata;
            if (n == 0) sync = 1'b0;
            if (n == 5) begin
                ready = 1'b0;
                valid = 12'hF00;
                data  = make_payload(16'hFACE);
            end
        end
        check_vec("R7 capture at start", got, exp);

        // R10: restart in the middle of a frame
        ready = 1'b1;
        valid = 12'hFFF;
        data  = make_payload(16'h0BAD);
        exp_a = build_frame(ready, valid, data);
        got_a = '0;
        @(negedge clk);
        sync = 1'b1;
        @(posedge clk);
        for (int n = 0; n <= 40; n++) begin
            @(negedge clk);
            got_a[FRM-1-n] = sdata;
            if (n == 0) sync = 1'b0;
        end
        sync  = 1'b1;
        ready = 1'b0;
        valid = 12'h3A5;
        data  = make_payload(16'h6006);
        exp_b = build_frame(ready, valid, data);
        for (int m = 0; m < FRM; m++) begin
            @(negedge clk);
            got[FRM-1-m] = sdata;
            if (m == 0) sync = 1'b0;
        end
        check_vec("R10 prefix before restart", {got_a[FRM-1:FRM-41], 215'd0},
                  {exp_a[FRM-1:FRM-41], 215'd0});
        check_vec("R10 restarted frame", got, exp_b);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule